// File: doc/BRIEF.md
# Four-Way Recency Tracker with Age Counters

This block keeps the exact least-recently-used order of the four ways in every set of a four-way set-associative cache. Each way of each set has a two-bit age. Age 0 marks the way used most recently and age 3 marks the way left unused the longest. When the cache reports an access with a set index, a way number and a valid strobe, the block rewrites the ages of that set. The accessed way drops to age 0. Every way that was younger than it moves one step older. Ways that were already older keep their age.

On a separate query port the cache gives a set index, and the block answers with the way to evict: the way whose age is 3. The answer is combinational and reflects the state as it stands at the start of the cycle. Tags, data and hit detection belong to the surrounding cache. A synchronous active-low reset puts every set into its starting order.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset, every set holds age w for way w (ways 0 to 3 hold ages 0, 1, 2, 3), so the victim of every set is way 3.
- R2: The victim output is the way whose age is 3 in the queried set, encoded as a 2-bit way number.
- R3: When an access to a set is accepted, the accessed way's age becomes 0 from the next cycle.
- R4: On an access, a way of that set is incremented by one only if its age was below the accessed way's old age; a way whose age was above it keeps its age.
- R5: The four ages of each set always form a permutation of 0 to 3, so exactly one way is the victim.
- R6: A query reads the state at the start of the cycle; an access to the same set in that cycle changes the victim only from the next cycle.
- R7: An access to one set leaves the ages of every other set unchanged.
- R8: When the access strobe is low, no set changes, whatever the set and way inputs carry.
- R9: A repeated access to the way that already has age 0 leaves the set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_set | input | IDX_W (6) | Set index of the access |
| acc_way | input | 2 | Way used by the access |
| qry_set | input | IDX_W (6) | Set index of the victim query |
| victim_way | output | 2 | Way with age 3 in the queried set |

## Verification
The hardest state to reach from the ports is a set whose ages have been reordered many times, so that an access hits a way in the middle of the order. Only then does the rule that increments some ages and holds others come into play. A hand-computed vector table walks one set through such middle-of-order accesses, including a repeat of the most recent way and strobes held low. A long pseudo-random stream over several sets then runs against an age model kept in the bench. A directed step applies an access and a query to the same set in one cycle and samples the victim before and after the edge.

// File: rtl/lru_pkg.sv
// Shared types for the recency tracker.
// Assumes exactly four ways, so both the way number and the age are 2 bits.
package lru_pkg;
    localparam int WAYS  = 4;
    localparam int WAY_W = $clog2(WAYS);
    localparam int AGE_W = $clog2(WAYS);

    typedef logic [AGE_W-1:0]      age_t;
    typedef logic [WAY_W-1:0]      way_t;
    typedef age_t [WAYS-1:0]       age_row_t;
endpackage

// File: rtl/lru_age_update.sv
// Computes the next ages of one set after an access to way acc_way.
// Assumes row_in is a permutation of 0..WAYS-1; the output then is one as well.
module lru_age_update
    import lru_pkg::*;
(
    input  age_row_t row_in,
    input  way_t     acc_way,
    output age_row_t row_out
);
    age_t old_age;

    // Pick the accessed way's age before the update.
    always_comb old_age = row_in[acc_way];

    // The accessed way becomes youngest; younger ways age by one; older ways hold.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            if (way_t'(w) == acc_way)
                row_out[w] = '0;
            else if (row_in[w] < old_age)
                row_out[w] = age_t'(row_in[w] + 1'b1);
            else
                row_out[w] = row_in[w];
        end
    end
endmodule

// File: rtl/lru_victim_pick.sv
// Returns the way whose age is the oldest value (WAYS-1) in one set.
// Assumes the ages form a permutation, so exactly one way matches.
module lru_victim_pick
    import lru_pkg::*;
(
    input  age_row_t row,
    output way_t     victim
);
    // Scan the ways for the oldest age.
    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (row[w] == age_t'(WAYS-1))
                victim = way_t'(w);
        end
    end
endmodule

// File: rtl/lru_set_store.sv
// Holds the ages of every set, with one write port and two read ports.
// Assumes a synchronous active-low reset; reset loads age w into way w.
module lru_set_store
    import lru_pkg::*;
#(
    parameter int NUM_SETS = 64,
    localparam int IDX_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_set,
    input  age_row_t         wr_row,
    input  logic [IDX_W-1:0] rd_a_set,
    output age_row_t         rd_a_row,
    input  logic [IDX_W-1:0] rd_b_set,
    output age_row_t         rd_b_row
);
    age_row_t mem_q [NUM_SETS];

    // Reset every set to the starting order, else write the updated set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    mem_q[s][w] <= age_t'(w);
        end else if (wr_en) begin
            mem_q[wr_set] <= wr_row;
        end
    end

    // Read both ports from the current state.
    always_comb rd_a_row = mem_q[rd_a_set];
    always_comb rd_b_row = mem_q[rd_b_set];

    // Mark which age values occur in the queried set.
    logic [WAYS-1:0] seen_age;
    always_comb begin
        seen_age = '0;
        for (int w = 0; w < WAYS; w++)
            seen_age[rd_b_row[w]] = 1'b1;
    end

    // R5: every age value occurs once in the queried set.
    assert_age_permutation_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&seen_age));

    // R7: a set that is not written keeps its ages.
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_hold
        assert_untouched_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_set == IDX_W'(s)) |=> $stable(mem_q[s]));
    end
endmodule

// File: rtl/lru_age_tracker.sv
// Top of the recency tracker: applies accesses and answers victim queries.
// Assumes acc_way and victim_way are way numbers 0..3; the query is combinational.
module lru_age_tracker
    import lru_pkg::*;
#(
    parameter int NUM_SETS = 64,
    localparam int IDX_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_set,
    input  logic [1:0]       acc_way,
    input  logic [IDX_W-1:0] qry_set,
    output logic [1:0]       victim_way
);
    age_row_t acc_row;
    age_row_t next_row;
    age_row_t qry_row;
    way_t     victim;

    lru_set_store #(.NUM_SETS(NUM_SETS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_valid),
        .wr_set   (acc_set),
        .wr_row   (next_row),
        .rd_a_set (acc_set),
        .rd_a_row (acc_row),
        .rd_b_set (qry_set),
        .rd_b_row (qry_row)
    );

    lru_age_update u_update (
        .row_in  (acc_row),
        .acc_way (acc_way),
        .row_out (next_row)
    );

    lru_victim_pick u_pick (
        .row    (qry_row),
        .victim (victim)
    );

    // Drive the victim port from the picker.
    always_comb victim_way = victim;

    // R3: after an access, the accessed way reads back as age 0.
    assert_accessed_youngest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (acc_set != $past(acc_set)) || (acc_row[$past(acc_way)] == '0));

    // R4: a way older than the accessed way keeps its age.
    for (genvar w = 0; w < WAYS; w++) begin : g_older
        assert_older_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_way != way_t'(w) && acc_row[w] > acc_row[acc_way])
            |=> (acc_set != $past(acc_set)) || (acc_row[w] == $past(acc_row[w])));
    end
endmodule

// File: tb/sim_lru_age_tracker.sv
module sim_lru_age_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [5:0] acc_set = '0;
    logic [1:0] acc_way = '0;
    logic [5:0] qry_set = '0;
    logic [1:0] victim_way;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [1:0] mdl [64][4];

    always #2 clk = ~clk;

    lru_age_tracker u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_way(acc_way), .qry_set(qry_set), .victim_way(victim_way)
    );

    // Vector layout: {valid, set[5:0], way[1:0], expected victim of set 5}
    localparam logic [10:0] VEC [10] = '{
        {1'b1, 6'd5, 2'd3, 2'd2},
        {1'b1, 6'd5, 2'd2, 2'd1},
        {1'b1, 6'd5, 2'd0, 2'd1},
        {1'b1, 6'd5, 2'd0, 2'd1},
        {1'b1, 6'd5, 2'd1, 2'd3},
        {1'b0, 6'd5, 2'd3, 2'd3},
        {1'b1, 6'd6, 2'd3, 2'd3},
        {1'b1, 6'd5, 2'd2, 2'd3},
        {1'b1, 6'd5, 2'd3, 2'd0},
        {1'b1, 6'd5, 2'd1, 2'd0}
    };
    string vec_req [10] = '{"R3", "R4", "R4", "R9", "R3", "R8", "R7", "R4", "R2", "R4"};

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: victim_way=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 64; s++)
            for (int w = 0; w < 4; w++)
                mdl[s][w] = 2'(w);
    endtask

    task automatic model_access(input int s, input int way);
        logic [1:0] old;
        old = mdl[s][way];
        for (int w = 0; w < 4; w++) begin
            if (w == way) mdl[s][w] = 2'd0;
            else if (mdl[s][w] < old) mdl[s][w] = mdl[s][w] + 2'd1;
        end
    endtask

    function automatic logic [1:0] model_victim(input int s);
        logic [1:0] v = 2'd0;
        for (int w = 0; w < 4; w++)
            if (mdl[s][w] == 2'd3) v = 2'(w);
        return v;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: finished=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every set starts with way 3 as victim.
        foreach (VEC[i]) begin end
        for (int q = 0; q < 64; q += 9) begin
            qry_set = 6'(q);
            #1 check("R1", victim_way, 2'd3);
        end

        // Vector table on set 5.
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            acc_valid = VEC[i][10];
            acc_set   = VEC[i][9:4];
            acc_way   = VEC[i][3:2];
            qry_set   = 6'd5;
            if (VEC[i][10]) model_access(int'(VEC[i][9:4]), int'(VEC[i][3:2]));
            @(posedge clk);
            @(negedge clk);
            acc_valid = 1'b0;
            #1 check(vec_req[i], victim_way, VEC[i][1:0]);
            check("R2", victim_way, model_victim(5));
        end

        // R6: same-cycle access and query on set 5 (ages 3,0,2,1 -> 0,1,3,2).
        @(negedge clk);
        acc_valid = 1'b1; acc_set = 6'd5; acc_way = 2'd0; qry_set = 6'd5;
        #1 check("R6", victim_way, 2'd0);
        model_access(5, 0);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        #1 check("R6", victim_way, 2'd2);

        // R5: pseudo-random stream over sets 0..7 against the model.
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            acc_valid = lfsr[0] | lfsr[1];
            acc_set   = {3'd0, lfsr[4:2]};
            acc_way   = lfsr[6:5];
            if (acc_valid) model_access(int'(acc_set), int'(acc_way));
            @(posedge clk);
            @(negedge clk);
            acc_valid = 1'b0;
            qry_set = {3'd0, lfsr[10:8]};
            #1 check("R5", victim_way, model_victim(int'(qry_set)));
            qry_set = 6'd40;
            #0 check("R7", victim_way, model_victim(40));
        end

        // R1: reset in mid-run wins over an access in the same cycle.
        @(negedge clk);
        rst_n = 1'b0; acc_valid = 1'b1; acc_set = 6'd2; acc_way = 2'd3;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; acc_valid = 1'b0;
        model_reset();
        for (int q = 0; q < 8; q++) begin
            qry_set = 6'(q);
            #1 check("R1", victim_way, 2'd3);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule